// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Request and Warning Logic

This block holds outgoing audio samples between software and a serializer. Software writes 32-bit samples through a small register port. The serializer takes one word per audio word slot. The queue holds 32 words. Its read and write pointers are 6 bits wide: the low 5 bits index the storage and the top bit marks a wrap. Both pointers can be read back in one status word.

The block derives three conditions from the queue. The request condition means the fill level has fallen to the programmed watermark. The warning condition means the transmitter is enabled and the queue is empty. The error condition is a sticky underrun record. Enable bits route the request and the warning to a DMA request line. Separate enable bits route all three conditions to an interrupt line.

Software can empty the queue at once with a self-clearing flush bit. When software turns the transmitter off, the transmitter stays active until the serializer reports the end of a frame. Only then does it stop.

Top module: `audio_txq`

## Requirements
- R1: After reset the queue is empty, both pointers are 0, the transmitter is inactive, every enable bit and flag reads 0, and `dma_req`, `irq` and `slot_data` are 0.
- R2: A write to address 2 appends `reg_wdata` to the queue. A `slot_pop` while the transmitter is active takes the oldest word. That word appears on `slot_data` in the cycle after the pop and stays there until the next pop.
- R3: The queue is full when the low 5 bits of the two pointers are equal and their top bits differ (32 words). A write to address 2 while the queue is full changes neither the pointers nor the stored contents.
- R4: The request flag, bit 8 of the control word at address 0, reads 1 exactly when the transmitter is active and the fill level (write pointer minus read pointer, modulo 64) is less than or equal to the watermark. The watermark is written and read in bits 4:0 of address 1.
- R5: The warning flag, bit 9 of the control word, reads 1 exactly when the transmitter is active and the queue is empty.
- R6: A `slot_pop` while the transmitter is active and the queue is empty is an underrun. In that case `slot_data` becomes 0 in the next cycle, the read pointer does not move, and the error flag (bit 10) is set.
- R7: The error flag stays set until a control write carries 1 in bit 10. A control write with 0 in bit 10 leaves the flag unchanged. If an underrun and a clearing write fall in the same cycle, the flag remains set.
- R8: The control word holds the routing enables: bit 0 request-to-DMA, bit 1 warning-to-DMA, bit 4 request-to-interrupt, bit 5 warning-to-interrupt, bit 6 error-to-interrupt. `dma_req` is the OR of each DMA-routed flag with its enable. `irq` is the OR of each flag with its interrupt enable.
- R9: A control write with 1 in bit 12 empties the queue. The read pointer takes the value of the write pointer in the next cycle. Bit 12 always reads 0.
- R10: Address 3 reads the read pointer in bits 5:0 and the write pointer in bits 21:16. All other bits read 0.
- R11: A control write with 1 in bit 15 makes the transmitter active in the next cycle. After a control write with 0 in bit 15, the transmitter stays active, and bit 15 and `tx_active` keep reading 1, until a `frame_end` pulse arrives in a later cycle.
- R12: A `slot_pop` while the transmitter is inactive is ignored. The pointers, `slot_data` and the error flag are all unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 watermark, 2 sample data, 3 pointers |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| slot_pop | input | 1 | Serializer takes one word |
| frame_end | input | 1 | Serializer reports the last bit of a frame |
| slot_data | output | 32 | Word taken by the most recent pop |
| tx_active | output | 1 | Transmitter is effectively active |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. The serializer can underrun on an empty queue in the very cycle that software writes 1 to clear the error flag. A directed case drives both in one cycle. The error bit must then still read 1, and a later clearing write alone must bring it to 0. The random phase makes pops independent of register writes, so it also produces further collisions of pops with clears, pushes and flushes. The bench's reference model predicts the same outcome for each of them: set wins, and the queue end that each side touches is updated.

// File: rtl/audio_txq_pkg.sv
package audio_txq_pkg;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_WMARK = 2'd1,
    RA_DATA  = 2'd2,
    RA_PTRS  = 2'd3
  } reg_addr_e;

  // control word bit positions
  localparam int B_REQ_DMA  = 0;
  localparam int B_WARN_DMA = 1;
  localparam int B_REQ_IRQ  = 4;
  localparam int B_WARN_IRQ = 5;
  localparam int B_ERR_IRQ  = 6;
  localparam int B_REQ_FLG  = 8;
  localparam int B_WARN_FLG = 9;
  localparam int B_ERR_FLG  = 10;
  localparam int B_FLUSH    = 12;
  localparam int B_TXEN     = 15;

  // pointer word: read pointer at bit 0, write pointer here
  localparam int PTR_WR_LSB = 16;

  typedef struct packed {
    logic req;
    logic warn;
    logic err;
  } cond_t;

  typedef struct packed {
    logic req_dma;
    logic warn_dma;
    logic req_irq;
    logic warn_irq;
    logic err_irq;
  } route_t;

  function automatic logic dma_of(cond_t c, route_t r);
    return (c.req & r.req_dma) | (c.warn & r.warn_dma);
  endfunction

  function automatic logic irq_of(cond_t c, route_t r);
    return (c.req & r.req_irq) | (c.warn & r.warn_irq) | (c.err & r.err_irq);
  endfunction

endpackage

// File: rtl/audio_txq_store.sv
module audio_txq_store #(
  parameter int DW = 32,
  parameter int AW = 5,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          underrun,
  output logic [DW-1:0] slot_data
);

  function automatic logic [PW-1:0] fill_of(logic [PW-1:0] rp, logic [PW-1:0] wp);
    return wp - rp;
  endfunction

  function automatic logic is_full(logic [PW-1:0] rp, logic [PW-1:0] wp);
    return (rp[AW-1:0] == wp[AW-1:0]) && (rp[AW] != wp[AW]);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic          push_ok;
  logic          pop_take;

  assign empty    = (rd_ptr == wr_ptr);
  assign full     = is_full(rd_ptr, wr_ptr);
  assign level    = fill_of(rd_ptr, wr_ptr);
  assign push_ok  = push && !full && !flush;
  assign pop_take = pop && !empty;
  assign underrun = pop && empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (push_ok) begin
      wr_ptr <= wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
    end else if (flush) begin
      rd_ptr <= wr_ptr;
    end else if (pop_take) begin
      rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_data <= '0;
    end else if (pop) begin
      slot_data <= empty ? '0 : mem[rd_ptr[AW-1:0]];
    end
  end

  // R3
  full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush) |=> (wr_ptr == $past(wr_ptr)));

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= PW'(DEPTH)));

  // R6
  underrun_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !flush) |=> (rd_ptr == $past(rd_ptr)));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/audio_txq_flags.sv
module audio_txq_flags
  import audio_txq_pkg::*;
#(
  parameter int AW = 5,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_active,
  input  logic [PW-1:0] level,
  input  logic          empty,
  input  logic [AW-1:0] wmark,
  input  logic          underrun,
  input  logic          err_clr,
  input  route_t        route,
  output cond_t         cond,
  output logic          dma_req,
  output logic          irq
);

  logic err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (underrun) begin
      err_q <= 1'b1;
    end else if (err_clr) begin
      err_q <= 1'b0;
    end
  end

  always_comb begin
    cond.req  = tx_active && (level <= {1'b0, wmark});
    cond.warn = tx_active && empty;
    cond.err  = err_q;
  end

  assign dma_req = dma_of(cond, route);
  assign irq     = irq_of(cond, route);

  // R7
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> cond.err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond.err && !err_clr) |=> cond.err);

endmodule

// File: rtl/audio_txq_regs.sv
module audio_txq_regs
  import audio_txq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          frame_end,
  input  cond_t         cond,
  input  logic [PW-1:0] rd_ptr,
  input  logic [PW-1:0] wr_ptr,
  output route_t        route,
  output logic [AW-1:0] wmark,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          flush,
  output logic          err_clr,
  output logic          tx_active
);

  logic ctrl_wr;
  logic wm_wr;
  logic te_sw;

  assign ctrl_wr   = reg_wr && (reg_addr == RA_CTRL);
  assign wm_wr     = reg_wr && (reg_addr == RA_WMARK);
  assign push      = reg_wr && (reg_addr == RA_DATA);
  assign push_data = reg_wdata;
  assign flush     = ctrl_wr && reg_wdata[B_FLUSH];
  assign err_clr   = ctrl_wr && reg_wdata[B_ERR_FLG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route <= '0;
      te_sw <= 1'b0;
    end else if (ctrl_wr) begin
      route.req_dma  <= reg_wdata[B_REQ_DMA];
      route.warn_dma <= reg_wdata[B_WARN_DMA];
      route.req_irq  <= reg_wdata[B_REQ_IRQ];
      route.warn_irq <= reg_wdata[B_WARN_IRQ];
      route.err_irq  <= reg_wdata[B_ERR_IRQ];
      te_sw          <= reg_wdata[B_TXEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmark <= '0;
    end else if (wm_wr) begin
      wmark <= reg_wdata[AW-1:0];
    end
  end

  // deferred stop: the clear takes hold only at a frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
    end else if (ctrl_wr && reg_wdata[B_TXEN]) begin
      tx_active <= 1'b1;
    end else if (!te_sw && frame_end) begin
      tx_active <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[B_REQ_DMA]  = route.req_dma;
        reg_rdata[B_WARN_DMA] = route.warn_dma;
        reg_rdata[B_REQ_IRQ]  = route.req_irq;
        reg_rdata[B_WARN_IRQ] = route.warn_irq;
        reg_rdata[B_ERR_IRQ]  = route.err_irq;
        reg_rdata[B_REQ_FLG]  = cond.req;
        reg_rdata[B_WARN_FLG] = cond.warn;
        reg_rdata[B_ERR_FLG]  = cond.err;
        reg_rdata[B_TXEN]     = tx_active;
      end
      RA_WMARK: reg_rdata[AW-1:0] = wmark;
      RA_PTRS: begin
        reg_rdata[PW-1:0]              = rd_ptr;
        reg_rdata[PTR_WR_LSB +: PW]    = wr_ptr;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R11
  tx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !frame_end) |=> tx_active);

  // R11
  tx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[B_TXEN]) |=> tx_active);

endmodule

// File: rtl/audio_txq.sv
module audio_txq
  import audio_txq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          slot_pop,
  input  logic          frame_end,
  output logic [DW-1:0] slot_data,
  output logic          tx_active,
  output logic          dma_req,
  output logic          irq
);

  route_t        route;
  cond_t         cond;
  logic [AW-1:0] wmark;
  logic          push;
  logic [DW-1:0] push_data;
  logic          flush;
  logic          err_clr;
  logic          pop_q;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] level;
  logic          empty;
  logic          full;
  logic          underrun;

  // pops only count while the transmitter runs
  assign pop_q = slot_pop && tx_active;

  audio_txq_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .frame_end (frame_end),
    .cond      (cond),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .route     (route),
    .wmark     (wmark),
    .push      (push),
    .push_data (push_data),
    .flush     (flush),
    .err_clr   (err_clr),
    .tx_active (tx_active)
  );

  audio_txq_store #(.DW(DW), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop_q),
    .flush     (flush),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .level     (level),
    .empty     (empty),
    .full      (full),
    .underrun  (underrun),
    .slot_data (slot_data)
  );

  audio_txq_flags #(.AW(AW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .level     (level),
    .empty     (empty),
    .wmark     (wmark),
    .underrun  (underrun),
    .err_clr   (err_clr),
    .route     (route),
    .cond      (cond),
    .dma_req   (dma_req),
    .irq       (irq)
  );

  // R12
  idle_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pop && !tx_active && !flush) |=> (rd_ptr == $past(rd_ptr)));

endmodule

// File: tb/audio_txq_bench.sv
module audio_txq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        slot_pop = 1'b0;
  logic        frame_end = 1'b0;
  logic [31:0] slot_data;
  logic        tx_active;
  logic        dma_req;
  logic        irq;

  int total = 0;
  int bad = 0;

  // reference model
  logic [31:0] m_q[$];
  bit [5:0]    m_rd, m_wr;
  bit          m_err, m_act, m_te;
  bit [4:0]    m_wm;
  bit          m_rdma, m_wdma, m_rirq, m_wirq, m_eirq;
  logic [31:0] m_slot;

  audio_txq u_audio_txq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_pop(slot_pop),
    .frame_end(frame_end), .slot_data(slot_data), .tx_active(tx_active),
    .dma_req(dma_req), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_empty();
    return m_rd == m_wr;
  endfunction

  function automatic bit m_full();
    return (m_rd[4:0] == m_wr[4:0]) && (m_rd[5] != m_wr[5]);
  endfunction

  function automatic bit m_req();
    bit [5:0] lvl = m_wr - m_rd;
    return m_act && (lvl <= {1'b0, m_wm});
  endfunction

  function automatic bit m_warn();
    return m_act && m_empty();
  endfunction

  function automatic logic [31:0] m_ctrl();
    logic [31:0] w = '0;
    w[0] = m_rdma; w[1] = m_wdma; w[4] = m_rirq; w[5] = m_wirq; w[6] = m_eirq;
    w[8] = m_req(); w[9] = m_warn(); w[10] = m_err; w[15] = m_act;
    return w;
  endfunction

  function automatic logic [31:0] ctrl_word(bit te, bit [4:0] en, bit fl, bit ec);
    logic [31:0] w = '0;
    w[0] = en[0]; w[1] = en[1]; w[4] = en[2]; w[5] = en[3]; w[6] = en[4];
    w[10] = ec; w[12] = fl; w[15] = te;
    return w;
  endfunction

  // advance the model across one clock edge with the inputs of that edge
  task automatic model_edge(bit wr, logic [1:0] a, logic [31:0] d, bit pop, bit fe);
    bit cw  = wr && (a == 2'd0);
    bit pq  = pop && m_act;
    bit emp = m_empty();
    bit ful = m_full();
    bit und = pq && emp;
    bit old_te = m_te;
    if (pq) m_slot = emp ? 32'h0 : m_q[0];
    if (cw && d[12]) begin
      m_q.delete();
      m_rd = m_wr;
    end else begin
      if (pq && !emp) begin
        void'(m_q.pop_front());
        m_rd = m_rd + 6'd1;
      end
      if (wr && a == 2'd2 && !ful) begin
        m_q.push_back(d);
        m_wr = m_wr + 6'd1;
      end
    end
    if (und) m_err = 1'b1;
    else if (cw && d[10]) m_err = 1'b0;
    if (cw) begin
      m_rdma = d[0]; m_wdma = d[1]; m_rirq = d[4]; m_wirq = d[5]; m_eirq = d[6];
      m_te = d[15];
    end
    if (cw && d[15]) m_act = 1'b1;
    else if (!old_te && fe) m_act = 1'b0;
    if (wr && a == 2'd1) m_wm = d[4:0];
  endtask

  task automatic read_reg(logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    bit r, w;
    r = m_req(); w = m_warn();
    read_reg(2'd0, v);
    check("R4 R5 R7 R8 R9 R11 ctrl word", v, m_ctrl());
    read_reg(2'd1, v);
    check("R4 watermark word", v, {27'd0, m_wm});
    read_reg(2'd3, v);
    check("R10 pointer word", v, {10'd0, m_wr, 10'd0, m_rd});
    reg_addr = 2'd0;
    check("R2 R6 slot_data", slot_data, m_slot);
    check("R8 dma_req", {31'd0, dma_req}, {31'd0, (r & m_rdma) | (w & m_wdma)});
    check("R8 irq", {31'd0, irq}, {31'd0, (r & m_rirq) | (w & m_wirq) | (m_err & m_eirq)});
    check("R11 tx_active", {31'd0, tx_active}, {31'd0, m_act});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit wr, logic [1:0] a, logic [31:0] d, bit pop, bit fe);
    reg_wr = wr; reg_addr = a; reg_wdata = d; slot_pop = pop; frame_end = fe;
    @(posedge clk);
    model_edge(wr, a, d, pop, fe);
    #1;
    reg_wr = 1'b0; reg_wdata = '0; slot_pop = 1'b0; frame_end = 1'b0;
    check_all();
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_a11c));
    m_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_reg(2'd0, v); check("R1 ctrl after reset", v, 32'h0);
    read_reg(2'd3, v); check("R1 pointers after reset", v, 32'h0);
    reg_addr = 2'd0;
    check("R1 slot_data after reset", slot_data, 32'h0);
    check("R1 outputs after reset", {29'd0, tx_active, dma_req, irq}, 32'h0);

    // enable with all routes, watermark 4
    step(1'b1, 2'd0, ctrl_word(1'b1, 5'h1f, 1'b0, 1'b0), 1'b0, 1'b0);
    step(1'b1, 2'd1, 32'd4, 1'b0, 1'b0);

    // R3 fill beyond capacity
    for (int i = 0; i < 33; i++) step(1'b1, 2'd2, 32'hC0DE_0000 + i, 1'b0, 1'b0);
    read_reg(2'd3, v);
    check("R3 overfill leaves write pointer at wrap", v, 32'h0020_0000);

    // R2 drain in order
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
      check("R2 drained order", slot_data, 32'hC0DE_0000 + i);
    end

    // R6 underrun
    step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
    check("R6 underrun slot zero", slot_data, 32'h0);
    read_reg(2'd0, v);
    check("R6 error set", {31'd0, v[10]}, 32'd1);

    // R7 underrun and clear in the same cycle
    step(1'b1, 2'd0, ctrl_word(1'b1, 5'h1f, 1'b0, 1'b1), 1'b1, 1'b0);
    read_reg(2'd0, v);
    check("R7 set beats clear", {31'd0, v[10]}, 32'd1);
    step(1'b1, 2'd0, ctrl_word(1'b1, 5'h1f, 1'b0, 1'b0), 1'b0, 1'b0);
    read_reg(2'd0, v);
    check("R7 write zero keeps error", {31'd0, v[10]}, 32'd1);
    step(1'b1, 2'd0, ctrl_word(1'b1, 5'h1f, 1'b0, 1'b1), 1'b0, 1'b0);
    read_reg(2'd0, v);
    check("R7 clear by one", {31'd0, v[10]}, 32'd0);

    // R9 flush
    for (int i = 0; i < 3; i++) step(1'b1, 2'd2, 32'h1234_0000 + i, 1'b0, 1'b0);
    step(1'b1, 2'd0, ctrl_word(1'b1, 5'h1f, 1'b1, 1'b0), 1'b0, 1'b0);
    read_reg(2'd3, v);
    check("R9 flush equalises pointers", {26'd0, v[5:0]}, {26'd0, v[21:16]});
    read_reg(2'd0, v);
    check("R9 flush bit reads zero", {31'd0, v[12]}, 32'd0);

    // R11 deferred stop
    step(1'b1, 2'd2, 32'hBEEF_0001, 1'b0, 1'b0);
    step(1'b1, 2'd0, ctrl_word(1'b0, 5'h1f, 1'b0, 1'b0), 1'b0, 1'b1);
    check("R11 still active after clear", {31'd0, tx_active}, 32'd1);
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
    check("R11 active until frame end", {31'd0, tx_active}, 32'd1);
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    check("R11 stops at frame end", {31'd0, tx_active}, 32'd0);

    // R12 pop while inactive
    read_reg(2'd3, v);
    step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
    begin
      logic [31:0] v2;
      read_reg(2'd3, v2);
      check("R12 pointers unchanged", v2, v);
      read_reg(2'd0, v2);
      check("R12 error unchanged", {31'd0, v2[10]}, 32'd0);
    end

    // random phase
    step(1'b1, 2'd0, ctrl_word(1'b1, 5'h1f, 1'b0, 1'b0), 1'b0, 1'b0);
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      bit pop = ($urandom_range(0, 2) == 0);
      bit fe = ($urandom_range(0, 4) == 0);
      if (r < 40)
        step(1'b1, 2'd2, $urandom, pop, fe);
      else if (r < 45)
        step(1'b1, 2'd1, $urandom, pop, fe);
      else if (r < 52)
        step(1'b1, 2'd0,
             ctrl_word($urandom_range(0, 3) != 0, 5'($urandom),
                       $urandom_range(0, 9) == 0, 1'($urandom)), pop, fe);
      else
        step(1'b0, 2'd0, 32'h0, pop, fe);
    end

    summary();
    $finish;
  end
endmodule